// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Byte

This block is the arithmetic core of an accumulator-style 8-bit datapath. Each cycle it can perform one of five operations: add, add with carry, subtract with borrow, multiply or divide. The operation works on the accumulator, a source operand and the B register. The new accumulator and B values come out combinationally in the same cycle. The surrounding datapath decides whether to store them.

The block owns the 8-bit program status byte. The flag byte has this layout:

- bit 7: carry
- bit 6: auxiliary (nibble) carry
- bit 5: a free user flag
- bits 4:3: working-register bank select
- bit 2: overflow
- bit 1: spare
- bit 0: parity

The status byte register is updated at the clock edge that ends an operation. Software-style code can also load bits 7:1 of the status byte in one go through a direct-write port. The parity bit is never written directly. Hardware refreshes it on every clock, so it always tracks the accumulator value that the datapath holds after that cycle.

Top module: `accum_alu`

## Requirements
- R1: While `rst_n` is low, `psw_o` reads 00h.
- R2: With `op_valid_i` high, operation code 0 (ADD) drives `acc_o` with (acc_i + src_i) mod 256 and leaves `b_o` = `b_i`. At the next edge, bit 7 takes the carry out of bit 7, bit 6 takes the carry out of bit 3, and bit 2 is set exactly when the two's-complement sum leaves the range -128..127.
- R3: Code 1 (ADDC) behaves as R2 but also adds the carry that `psw_o` bit 7 held before the edge.
- R4: Code 2 (SUBB) drives `acc_o` with (acc_i - src_i - old carry) mod 256. Bit 7 is set on a borrow out of bit 7, bit 6 is set on a borrow out of bit 3, and bit 2 is set on signed overflow of the difference.
- R5: Code 3 (MUL) puts the low byte of acc_i * b_i on `acc_o` and the high byte on `b_o`. Bit 2 is set exactly when the product exceeds 255. Bits 7 and 6 are cleared.
- R6: Code 4 (DIV) with a nonzero `b_i` puts the quotient on `acc_o` and the remainder on `b_o`. Bits 7, 6 and 2 are cleared.
- R7: Code 4 with `b_i` = 0 drives `acc_o` = `acc_i` and `b_o` = `b_i`. It sets bit 2 and clears bits 7 and 6.
- R8: After every edge out of reset, `psw_o` bit 0 equals the XOR of all bits of the `acc_o` value seen before that edge. It is 1 for an odd count of ones.
- R9: Bits 5, 4, 3 and 1 of `psw_o` are changed only by a direct write. No arithmetic operation alters them.
- R10: A cycle with `psw_wr_i` high loads `psw_wdata_i` into bits 7:1 at the edge. This overrides any flag result of an operation in the same cycle. Parity still follows R8.
- R11: With `op_valid_i` low, or with a code of 5 to 7, `acc_o` = `acc_i` and `b_o` = `b_i`. Without a direct write, bits 7:1 of `psw_o` keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid_i | input | 1 | Perform the operation in `op_i` this cycle |
| op_i | input | 3 | Operation code: 0 ADD, 1 ADDC, 2 SUBB, 3 MUL, 4 DIV |
| acc_i | input | DW | Current accumulator |
| b_i | input | DW | Current B register, multiplier or divisor |
| src_i | input | DW | Second operand for add and subtract |
| psw_wr_i | input | 1 | Direct write of the status byte |
| psw_wdata_i | input | 7 | Value for status bits 7:1 |
| acc_o | output | DW | New accumulator value |
| b_o | output | DW | New B value |
| psw_o | output | 8 | Status byte |

## Verification
The hardest situation to reach from the ports is a flag outcome that depends on the incoming carry. Examples are an ADDC or SUBB whose nibble borrow or signed overflow appears only because of the carry-in, and a divide by zero arriving with arbitrary status bits already set. The bench reaches these by preceding every operation with a direct write. That write plants a chosen carry, arbitrary bank and user-flag bits, and stale overflow and auxiliary values. The bench then sweeps the accumulator and operand over a dense grid that includes 0, 7Fh-adjacent values and FFh for all five operations, and compares every result and flag with arithmetic done in integers.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  // Status byte bit positions (decoded by neighbouring logic, so fixed)
  localparam int unsigned SB_CY  = 7;
  localparam int unsigned SB_AC  = 6;
  localparam int unsigned SB_OV  = 2;
  localparam int unsigned SB_PAR = 0;
  localparam int unsigned SB_W   = 8;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;

endpackage

// File: rtl/accum_addsub.sv
// Adder/subtracter split at the nibble boundary so the half carry is a
// real carry of the chain rather than a separate adder.
module accum_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] s_i,
  input  logic          sub_i,
  input  logic          use_cy_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o
);

  localparam int unsigned NW = DW / 2;
  localparam int unsigned HW = DW - NW;

  logic [DW-1:0] opnd;
  logic          cin;
  logic [NW:0]   lo_sum;
  logic [HW:0]   hi_sum;
  logic          msb_cin;

  always_comb begin
    // Subtract as a + ~s + ~borrow; carries then invert into borrows.
    opnd    = sub_i ? ~s_i : s_i;
    cin     = (use_cy_i & cy_i) ^ sub_i;
    lo_sum  = {1'b0, a_i[NW-1:0]} + {1'b0, opnd[NW-1:0]} + {{NW{1'b0}}, cin};
    hi_sum  = {1'b0, a_i[DW-1:NW]} + {1'b0, opnd[DW-1:NW]} + {{HW{1'b0}}, lo_sum[NW]};
    res_o   = {hi_sum[HW-1:0], lo_sum[NW-1:0]};
    msb_cin = a_i[DW-1] ^ opnd[DW-1] ^ res_o[DW-1];
    cy_o    = hi_sum[HW] ^ sub_i;
    ac_o    = lo_sum[NW] ^ sub_i;
    ov_o    = msb_cin ^ hi_sum[HW];
  end

endmodule

// File: rtl/accum_mul.sv
module accum_mul #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic          big_o
);

  localparam int unsigned PW = 2 * DW;

  logic [PW-1:0] prod;

  always_comb begin
    prod  = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
    lo_o  = prod[DW-1:0];
    hi_o  = prod[PW-1:DW];
    big_o = |prod[PW-1:DW];
  end

endmodule

// File: rtl/accum_div.sv
// Single-cycle restoring divider: one compare/subtract stage per
// dividend bit, most significant bit first.
module accum_div #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] r_o,
  output logic          dz_o
);

  logic [DW-1:0] rem_w [0:DW];

  assign rem_w[0] = '0;

  for (genvar k = 0; k < DW; k++) begin : g_stage
    logic [DW:0]   shf;
    logic [DW-1:0] dif;
    logic          take;

    always_comb begin
      shf  = {rem_w[k], a_i[DW-1-k]};
      take = (shf >= {1'b0, d_i});
      dif  = shf[DW-1:0] - d_i;
    end

    assign q_o[DW-1-k] = take;
    assign rem_w[k+1]  = take ? dif : shf[DW-1:0];
  end

  assign r_o  = rem_w[DW];
  assign dz_o = (d_i == '0);

endmodule

// File: rtl/accum_psw_reg.sv
module accum_psw_reg
  import accum_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [7:1]   wr_data_i,
  input  logic         upd_en_i,
  input  arith_flags_t upd_flags_i,
  input  logic         par_i,
  output logic [SB_W-1:0] psw_o
);

  logic [SB_W-1:0] psw_q;
  logic [SB_W-1:0] psw_nxt;
  logic            flag_en;

  always_comb begin
    flag_en = wr_en_i | upd_en_i;
    psw_nxt = psw_q;
    if (wr_en_i) begin
      psw_nxt[7:1] = wr_data_i;
    end else if (upd_en_i) begin
      psw_nxt[SB_CY] = upd_flags_i.cy;
      psw_nxt[SB_AC] = upd_flags_i.ac;
      psw_nxt[SB_OV] = upd_flags_i.ov;
    end
    psw_nxt[SB_PAR] = par_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q <= '0;
    end else begin
      if (flag_en) begin
        psw_q[7:1] <= psw_nxt[7:1];
      end
      psw_q[SB_PAR] <= psw_nxt[SB_PAR];
    end
  end

  assign psw_o = psw_q;

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] src_i,
  input  logic          psw_wr_i,
  input  logic [7:1]    psw_wdata_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] b_o,
  output logic [7:0]    psw_o
);

  logic [SB_W-1:0] psw_q;
  logic            is_sub, is_addc, is_add, is_mul, is_div, arith;
  logic [DW-1:0]   as_res, mul_lo, mul_hi, div_q, div_r;
  logic            as_cy, as_ac, as_ov, mul_big, div_dz;
  arith_flags_t    flags;
  logic            par;

  always_comb begin
    is_add  = (op_i == OP_ADD) || (op_i == OP_ADDC);
    is_addc = (op_i == OP_ADDC);
    is_sub  = (op_i == OP_SUBB);
    is_mul  = (op_i == OP_MUL);
    is_div  = (op_i == OP_DIV);
    arith   = op_valid_i & (is_add | is_sub | is_mul | is_div);
  end

  accum_addsub #(.DW(DW)) u_addsub (
    .a_i      (acc_i),
    .s_i      (src_i),
    .sub_i    (is_sub),
    .use_cy_i (is_addc | is_sub),
    .cy_i     (psw_q[SB_CY]),
    .res_o    (as_res),
    .cy_o     (as_cy),
    .ac_o     (as_ac),
    .ov_o     (as_ov)
  );

  accum_mul #(.DW(DW)) u_mul (
    .a_i   (acc_i),
    .b_i   (b_i),
    .lo_o  (mul_lo),
    .hi_o  (mul_hi),
    .big_o (mul_big)
  );

  accum_div #(.DW(DW)) u_div (
    .a_i  (acc_i),
    .d_i  (b_i),
    .q_o  (div_q),
    .r_o  (div_r),
    .dz_o (div_dz)
  );

  // Result select; unused codes and idle cycles pass operands through.
  always_comb begin
    acc_o = acc_i;
    b_o   = b_i;
    flags = '0;
    if (op_valid_i) begin
      if (is_add || is_sub) begin
        acc_o    = as_res;
        flags.cy = as_cy;
        flags.ac = as_ac;
        flags.ov = as_ov;
      end else if (is_mul) begin
        acc_o    = mul_lo;
        b_o      = mul_hi;
        flags.ov = mul_big;
      end else if (is_div) begin
        if (div_dz) begin
          flags.ov = 1'b1;
        end else begin
          acc_o = div_q;
          b_o   = div_r;
        end
      end
    end
    par = ^acc_o;
  end

  accum_psw_reg u_psw (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (psw_wr_i),
    .wr_data_i   (psw_wdata_i),
    .upd_en_i    (arith),
    .upd_flags_i (flags),
    .par_i       (par),
    .psw_o       (psw_q)
  );

  assign psw_o = psw_q;

endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk
  import accum_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid_i,
  input logic [2:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] b_i,
  input logic          psw_wr_i,
  input logic [7:1]    psw_wdata_i,
  input logic [DW-1:0] acc_o,
  input logic [DW-1:0] b_o,
  input logic [7:0]    psw_o
);

  AST_MODE_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !psw_wr_i |=> $stable(psw_o[5:3]) && $stable(psw_o[1])); // R9

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    psw_wr_i |=> psw_o[7:1] == $past(psw_wdata_i)); // R10

  AST_PARITY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> psw_o[0] == $past(^acc_o)); // R8

  AST_MUL_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i == OP_MUL && !psw_wr_i) |=> psw_o[2] == ($past(b_o) != '0)); // R5

  AST_DIVZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i == OP_DIV && b_i == '0) |-> (acc_o == acc_i) && (b_o == b_i)); // R7

  AST_DIVZERO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i == OP_DIV && b_i == '0 && !psw_wr_i) |=> psw_o[2] && !psw_o[7] && !psw_o[6]); // R7

  AST_MULDIV_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && (op_i == OP_MUL || op_i == OP_DIV) && !psw_wr_i) |=> !psw_o[7] && !psw_o[6]); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid_i && !psw_wr_i) |=> $stable(psw_o[7:1])); // R11

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |-> (acc_o == acc_i) && (b_o == b_i)); // R11

endmodule

bind accum_alu accum_alu_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid_i  (op_valid_i),
  .op_i        (op_i),
  .acc_i       (acc_i),
  .b_i         (b_i),
  .psw_wr_i    (psw_wr_i),
  .psw_wdata_i (psw_wdata_i),
  .acc_o       (acc_o),
  .b_o         (b_o),
  .psw_o       (psw_o)
);

// File: tb/sim_accum_alu.sv
module sim_accum_alu;

  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          op_valid_i;
  logic [2:0]    op_i;
  logic [DW-1:0] acc_i, b_i, src_i;
  logic          psw_wr_i;
  logic [7:1]    psw_wdata_i;
  logic [DW-1:0] acc_o, b_o;
  logic [7:0]    psw_o;

  int checks;
  int failures;
  bit done;

  accum_alu #(.DW(DW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid_i  (op_valid_i),
    .op_i        (op_i),
    .acc_i       (acc_i),
    .b_i         (b_i),
    .src_i       (src_i),
    .psw_wr_i    (psw_wr_i),
    .psw_wdata_i (psw_wdata_i),
    .acc_o       (acc_o),
    .b_o         (b_o),
    .psw_o       (psw_o)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int par8(input int v);
    return $countones(v[7:0]) & 1;
  endfunction

  // Integer reference model of the requirements; the incoming B equals s.
  task automatic model(input int op, input int a, input int s, input int cin,
                       output int ea, output int eb, output int cy,
                       output int ac, output int ov);
    int r, c, sr;
    ea = a; eb = s; cy = 0; ac = 0; ov = 0;
    case (op)
      0, 1: begin
        c  = (op == 1) ? cin : 0;
        r  = a + s + c;
        ea = r & 255;
        cy = (r > 255);
        ac = (((a & 15) + (s & 15) + c) > 15);
        sr = sx(a) + sx(s) + c;
        ov = (sr > 127) || (sr < -128);
      end
      2: begin
        r  = a - s - cin;
        ea = r & 255;
        cy = (r < 0);
        ac = (((a & 15) - (s & 15) - cin) < 0);
        sr = sx(a) - sx(s) - cin;
        ov = (sr > 127) || (sr < -128);
      end
      3: begin
        r  = a * s;
        ea = r & 255;
        eb = r >> 8;
        ov = (r > 255);
      end
      default: begin
        if (s == 0) ov = 1;
        else begin
          ea = a / s;
          eb = a % s;
        end
      end
    endcase
  endtask

  // Preload status with a direct write, then run the operation.
  task automatic run_op(input int op, input int a, input int s, input int cin, input int mb);
    int w, ea, eb, cy, ac, ov;
    string req;
    w = (cin << 7) | (((a >> 1) & 1) << 6) | ((mb & 7) << 3) | ((s & 1) << 2) | (((mb >> 3) & 1) << 1);
    @(negedge clk);
    psw_wr_i    = 1'b1;
    psw_wdata_i = w[7:1];
    op_valid_i  = 1'b0;
    op_i        = op[2:0];
    acc_i       = a[7:0];
    b_i         = s[7:0];
    src_i       = s[7:0];
    #1;
    check("R11 idle acc", acc_o, a);
    check("R11 idle b", b_o, s);
    @(posedge clk); #1;
    check("R10 R8 write", psw_o, (w & 8'hFE) | par8(a));
    @(negedge clk);
    psw_wr_i   = 1'b0;
    op_valid_i = 1'b1;
    model(op, a, s, cin, ea, eb, cy, ac, ov);
    case (op)
      0: req = "R2";
      1: req = "R3";
      2: req = "R4";
      3: req = "R5";
      default: req = (s == 0) ? "R7" : "R6";
    endcase
    #1;
    check({req, " acc"}, acc_o, ea);
    check({req, " b"}, b_o, eb);
    @(posedge clk); #1;
    check({req, " R8 R9 status"}, psw_o,
          (cy << 7) | (ac << 6) | (w & 8'h3A) | (ov << 2) | par8(ea));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clk = 1'b0; rst_n = 1'b0;
    op_valid_i = 1'b0; op_i = '0; acc_i = 8'h5A; b_i = '0; src_i = '0;
    psw_wr_i = 1'b0; psw_wdata_i = '0;
    checks = 0; failures = 0; done = 1'b0;

    repeat (3) @(posedge clk);
    #1 check("R1 reset", psw_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // Corner cases of signed overflow and borrow
    run_op(0, 8'h80, 8'h80, 0, 0);
    run_op(0, 8'h7F, 8'h01, 0, 5);
    run_op(1, 8'h7F, 8'h00, 1, 9);
    run_op(1, 8'hFF, 8'h00, 1, 15);
    run_op(2, 8'h80, 8'h00, 1, 3);
    run_op(2, 8'h00, 8'hFF, 1, 12);
    run_op(3, 8'hFF, 8'hFF, 0, 6);
    run_op(4, 8'h00, 8'h00, 1, 10);

    // Dense sweep over all operations
    for (int a = 0; a < 256; a += 3) begin
      for (int s = 0; s < 256; s += 5) begin
        for (int op = 0; op < 5; op++) begin
          run_op(op, a, s, (a ^ s ^ op) & 1, (a + s + op) & 15);
        end
      end
    end

    // R11: reserved code with valid set passes through and holds flags
    @(negedge clk);
    psw_wr_i = 1'b1; psw_wdata_i = 7'h52; op_valid_i = 1'b0; acc_i = 8'h13;
    @(negedge clk);
    psw_wr_i = 1'b0; op_valid_i = 1'b1; op_i = 3'd5;
    acc_i = 8'h13; b_i = 8'h22; src_i = 8'h55;
    #1;
    check("R11 reserved acc", acc_o, 8'h13);
    check("R11 reserved b", b_o, 8'h22);
    @(posedge clk); #1;
    check("R11 reserved status", psw_o, 8'hA5);

    // R10: write and ADD in one cycle, write wins, parity from result
    @(negedge clk);
    psw_wr_i = 1'b1; psw_wdata_i = 7'h24; op_valid_i = 1'b1; op_i = 3'd0;
    acc_i = 8'hFF; src_i = 8'h01;
    #1 check("R2 acc wrap", acc_o, 8'h00);
    @(posedge clk); #1;
    check("R10 override", psw_o, 8'h48);

    // R11 and R8: idle cycle, flags hold, parity follows accumulator
    @(negedge clk);
    psw_wr_i = 1'b0; op_valid_i = 1'b0; acc_i = 8'h07;
    @(posedge clk); #1;
    check("R11 R8 idle", psw_o, 8'h49);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule